// File: doc/BRIEF.md
# Dual-Structure 16-bit Pseudo-Random Sequence Generator

This block is a 16-bit linear-feedback shift register. It produces one pseudo-random bit per enabled clock and exposes its full 16-bit state. The feedback polynomial is fixed at x^16 + x^14 + x^13 + x^11 + 1. Two run-time selects pick the structure and the polarity. The structure is either a single-feedback chain, which is the Fibonacci form, or distributed toggles, which is the Galois form. The polarity is either XOR or XNOR feedback. The register shifts right, and the rightmost bit is the serial output.

A synchronous seed write loads any starting value. For each polarity, one value traps the register forever, and a combinational flag reports when the state holds that value. With XNOR feedback the value after reset is not a trap, so the generator runs straight from reset without a seed. The output is a free-running stream gated only by the enable, so it has no back-pressure: a consumer that cannot accept a bit holds the enable low, and the state then freezes.

Top module: `lfsr16_gen`

## Requirements
- R1: A high `rst` on a clock edge sets the state to 0x0000. Reset takes priority over seed writes and stepping.
- R2: A high `seed_wr` on a clock edge loads `seed_val` into the state, even when `step_en` is also high.
- R3: While `step_en` and `seed_wr` are both low, the state does not change.
- R4: Fibonacci XOR (`galois_sel`=0, `xnor_sel`=0): next = {s[0]^s[2]^s[3]^s[5], s[15:1]}. For example, 0xACE1 steps to 0x5670.
- R5: Galois XOR (`galois_sel`=1, `xnor_sel`=0): next = (s>>1) ^ (s[0] ? 0xB400 : 0). For example, 0x0001 steps to 0xB400.
- R6: XNOR mode (`xnor_sel`=1) is the bitwise complement of the XOR machine. In the Fibonacci form the injected bit is inverted. In the Galois form, next = {1, s[15:1]} ^ (s[0] ? 0 : 0xB400).
- R7: `lockup` is high in the same cycle, with no clock edge needed, exactly when the state is 0x0000 under XOR or 0xFFFF under XNOR.
- R8: When the state is in its lockup value, stepping leaves it unchanged.
- R9: From any non-lockup state, each structure and polarity returns to its start after exactly 65535 steps and not earlier.
- R10: Under XNOR, the all-zero state left by reset steps normally without a seed. In the Fibonacci form it moves to 0x8000.
- R11: `bit_out` always equals bit 0 of the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advances the sequence by one step per edge |
| seed_wr | input | 1 | Seed write strobe |
| seed_val | input | 16 | Seed value |
| galois_sel | input | 1 | 0 = Fibonacci structure, 1 = Galois structure |
| xnor_sel | input | 1 | 0 = XOR feedback, 1 = XNOR feedback |
| bit_out | output | 1 | Serial output (rightmost state bit) |
| state_out | output | 16 | Current register state |
| lockup | output | 1 | State equals the trap value for the selected polarity |

## Verification
Reset, seed writes and steps each show up in `state_out` and `bit_out` one clock edge after the inputs that cause them. `lockup` is combinational, so it must follow a change of `xnor_sel` or of the state within the same cycle. The bench changes inputs and samples outputs 2 ns after the rising edge: a stepped result is read just after the edge that produced it, and the lockup flag is read before the next edge. The bench compares every step against its own arithmetic model. It also counts full periods in two configurations to confirm the 65535-step return.

// File: rtl/lfsr16_pkg.sv
package lfsr16_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
  typedef enum logic { FB_XOR = 1'b0, FB_XNOR = 1'b1 } fb_pol_e;
  typedef enum logic { ST_FIB = 1'b0, ST_GAL = 1'b1 } struct_e;
endpackage

// File: rtl/lfsr16_fib_next.sv
module lfsr16_fib_next #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = 16'hB400
) (
  input  logic [W-1:0] cur,
  input  logic         inv,
  output logic [W-1:0] nxt
);
  // Galois mask bit b maps to Fibonacci tap W-1-b when shifting right
  logic [W-1:0] tapsel;
  for (genvar i = 0; i < W; i++) begin : g_mirror
    assign tapsel[W-1-i] = MASK[i];
  end
  logic fb;
  assign fb  = (^(cur & tapsel)) ^ inv;
  assign nxt = {fb, cur[W-1:1]};
endmodule

// File: rtl/lfsr16_gal_next.sv
module lfsr16_gal_next #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = 16'hB400
) (
  input  logic [W-1:0] cur,
  input  logic         inv,
  output logic [W-1:0] nxt
);
  // XNOR form is the complement of the XOR machine acting on ~cur
  logic [W-1:0] shifted;
  logic         toggle;
  assign shifted = {inv, cur[W-1:1]};
  assign toggle  = cur[0] ^ inv;
  assign nxt     = shifted ^ ({W{toggle}} & MASK);
endmodule

// File: rtl/lfsr16_lockdet.sv
module lfsr16_lockdet #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         inv,
  output logic         trapped
);
  assign trapped = inv ? (&cur) : ~(|cur);
endmodule

// File: rtl/lfsr16_gen.sv
module lfsr16_gen
  import lfsr16_pkg::*;
#(
  parameter int unsigned W = LFSR_W,
  parameter logic [W-1:0] MASK = LFSR_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         seed_wr,
  input  logic [W-1:0] seed_val,
  input  logic         galois_sel,
  input  logic         xnor_sel,
  output logic         bit_out,
  output logic [W-1:0] state_out,
  output logic         lockup
);
  logic [W-1:0] st_q;
  logic [W-1:0] fib_nxt, gal_nxt, step_nxt;
  struct_e      st_kind;
  fb_pol_e      pol;

  assign st_kind = struct_e'(galois_sel);
  assign pol     = fb_pol_e'(xnor_sel);

  lfsr16_fib_next #(.W(W), .MASK(MASK)) u_fib (
    .cur(st_q), .inv(pol == FB_XNOR), .nxt(fib_nxt));
  lfsr16_gal_next #(.W(W), .MASK(MASK)) u_gal (
    .cur(st_q), .inv(pol == FB_XNOR), .nxt(gal_nxt));
  lfsr16_lockdet #(.W(W)) u_lock (
    .cur(st_q), .inv(pol == FB_XNOR), .trapped(lockup));

  assign step_nxt = (st_kind == ST_GAL) ? gal_nxt : fib_nxt;

  always_ff @(posedge clk) begin
    if (rst)          st_q <= '0;
    else if (seed_wr) st_q <= seed_val;
    else if (step_en) st_q <= step_nxt;
  end

  assign state_out = st_q;
  assign bit_out   = st_q[0];

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (state_out == '0));
  a_r2_seed_load: assert property (@(posedge clk) disable iff (rst)
    seed_wr |=> (state_out == $past(seed_val)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_wr) |=> $stable(state_out));
  a_r4_fib_shift: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_wr && !galois_sel) |=> (state_out[W-2:0] == $past(state_out[W-1:1])));
  a_r5_gal_top: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_wr && galois_sel) |=> (state_out[W-1] == $past(state_out[0])));
  a_r8_trap_stays: assert property (@(posedge clk) disable iff (rst)
    (lockup && step_en && !seed_wr) |=> $stable(state_out));
  a_r11_serial_bit: assert property (@(posedge clk) disable iff (rst)
    bit_out == state_out[0]);
endmodule

// File: tb/lfsr16_gen_tb.sv
module lfsr16_gen_tb;
  logic clk = 1'b0;
  logic rst, step_en, seed_wr, galois_sel, xnor_sel;
  logic [15:0] seed_val;
  logic bit_out, lockup;
  logic [15:0] state_out;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lfsr16_gen u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_wr(seed_wr),
    .seed_val(seed_val), .galois_sel(galois_sel), .xnor_sel(xnor_sel),
    .bit_out(bit_out), .state_out(state_out), .lockup(lockup));

  function automatic logic [15:0] model(input logic [15:0] s, input logic gal, input logic xn);
    logic [15:0] r;
    logic fb;
    if (!gal) begin
      fb = s[0] ^ s[2] ^ s[3] ^ s[5] ^ xn;
      r = {fb, s[15:1]};
    end else if (!xn) begin
      r = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    end else begin
      r = {1'b1, s[15:1]} ^ (s[0] ? 16'h0000 : 16'hB400);
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // step once and compare with model, including serial bit and flag
  task automatic step_chk(input string req);
    logic [15:0] e;
    e = model(state_out, galois_sel, xnor_sel);
    step_en = 1'b1; seed_wr = 1'b0;
    tick();
    chk(state_out == e, req, state_out, e);
    chk(bit_out == e[0], "R11", {15'd0, bit_out}, {15'd0, e[0]});
    chk(lockup == (xnor_sel ? (e == 16'hFFFF) : (e == 16'h0000)), "R7",
        {15'd0, lockup}, {15'd0, ~lockup});
  endtask

  task automatic load(input logic [15:0] v);
    seed_val = v; seed_wr = 1'b1; step_en = 1'b0;
    tick();
    seed_wr = 1'b0;
  endtask

  task automatic period(input logic [15:0] sd, input string req);
    logic early;
    early = 1'b0;
    load(sd);
    for (int n = 1; n <= 65535; n++) begin
      step_chk(req);
      if (n < 65535 && state_out == sd) early = 1'b1;
    end
    chk(state_out == sd && !early, "R9", state_out, sd);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; step_en = 1'b0; seed_wr = 1'b0; seed_val = 16'h0;
    galois_sel = 1'b0; xnor_sel = 1'b0;
    tick(); tick();
    chk(state_out == 16'h0000, "R1", state_out, 16'h0000);
    chk(lockup == 1'b1, "R7", {15'd0, lockup}, 16'd1);
    rst = 1'b0;

    // R8: XOR trap at zero
    step_en = 1'b1; tick(); tick();
    chk(state_out == 16'h0000, "R8", state_out, 16'h0000);

    // R7: flag follows polarity without a clock edge
    @(negedge clk);
    xnor_sel = 1'b1; #1;
    chk(lockup == 1'b0, "R7", {15'd0, lockup}, 16'd0);
    #2;

    // R10: XNOR Fibonacci from zero without a seed
    tick();
    chk(state_out == 16'h8000, "R10", state_out, 16'h8000);
    for (int k = 0; k < 20; k++) step_chk("R10");

    // R2: seed beats enable
    xnor_sel = 1'b0;
    seed_val = 16'hACE1; seed_wr = 1'b1; step_en = 1'b1;
    tick();
    chk(state_out == 16'hACE1, "R2", state_out, 16'hACE1);
    seed_wr = 1'b0;
    tick();
    chk(state_out == 16'h5670, "R4", state_out, 16'h5670);

    // R3: hold with enable low
    step_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(state_out == 16'h5670, "R3", state_out, 16'h5670);
    end

    // R4 / R9: full Fibonacci XOR period
    period(16'hACE1, "R4");

    // R5: Galois XOR literal and run
    galois_sel = 1'b1;
    load(16'h0001);
    step_en = 1'b1; tick();
    chk(state_out == 16'hB400, "R5", state_out, 16'hB400);
    for (int k = 0; k < 2000; k++) step_chk("R5");

    // R6: Fibonacci XNOR run
    galois_sel = 1'b0; xnor_sel = 1'b1;
    load(16'h0F0F);
    for (int k = 0; k < 2000; k++) step_chk("R6");

    // R6 / R9: full Galois XNOR period
    galois_sel = 1'b1;
    period(16'h1234, "R6");

    // R7 / R8: XNOR trap at all ones in both structures
    load(16'hFFFF);
    chk(lockup == 1'b1, "R7", {15'd0, lockup}, 16'd1);
    step_en = 1'b1; tick();
    chk(state_out == 16'hFFFF, "R8", state_out, 16'hFFFF);
    galois_sel = 1'b0; tick();
    chk(state_out == 16'hFFFF, "R8", state_out, 16'hFFFF);

    // R7: all ones under XOR is not a trap
    @(negedge clk);
    xnor_sel = 1'b0; #1;
    chk(lockup == 1'b0, "R7", {15'd0, lockup}, 16'd0);
    #2;
    for (int k = 0; k < 4; k++) step_chk("R4");

    // R1: reset beats seed write
    rst = 1'b1; seed_wr = 1'b1; seed_val = 16'hBEEF;
    tick();
    chk(state_out == 16'h0000, "R1", state_out, 16'h0000);
    rst = 1'b0; seed_wr = 1'b0;

    finish_run();
  end
endmodule